// File: doc/BRIEF.md
# Nibble SECDED Encoder and Decoder

This block protects a 4-bit data nibble with a single-error-correcting, double-error-detecting Hamming code. The result is an 8-bit codeword. The encode path takes a nibble and returns the codeword. The decode path takes a codeword that may be corrupted and returns the repaired nibble, together with a flag for a repaired error and a flag for an uncorrectable double error.

The two paths are independent. Each path has an input valid strobe and registers its result once, so its output valid is its input valid delayed by one clock. The check bits are even parity, and so is the overall parity bit.

The code uses 1-based position indices. Bit k-1 of the 8-bit vector holds position k. The check bits sit at the power-of-two positions 1, 2 and 4. The data bits fill positions 3, 5, 6 and 7, in ascending order of data bit. Position 8 holds the overall parity bit.

Top module: `secded_codec`

## Requirements
- R1: An encoded codeword carries data bit 0 in vector bit 2, data bit 1 in bit 4, data bit 2 in bit 5 and data bit 3 in bit 6.
- R2: The check bits are even parity. Bit 0 covers vector bits 0, 2, 4 and 6. Bit 1 covers vector bits 1, 2, 5 and 6. Bit 3 covers vector bits 3, 4, 5 and 6.
- R3: Bit 7 of the codeword makes the population count of all eight bits even.
- R4: The all-zero nibble encodes to the all-zero codeword.
- R5: A codeword with zero syndrome and even overall parity decodes to its own data bits, with both flags low.
- R6: A codeword with exactly one flipped bit among vector bits 0 to 6 decodes to the original nibble. The corrected flag is high and the double flag is low.
- R7: A codeword whose only flipped bit is bit 7 decodes to the original nibble. The corrected flag is high.
- R8: A codeword with exactly two flipped bits raises the double flag and lowers the corrected flag. The data output is the received data bits, unmodified.
- R9: On each path, the output valid equals that path's input valid from the previous clock.
- R10: The two decode flags are never high together, and neither is high while the decode output valid is low.
- R11: While reset is high, at the next edge both output valids and both flags go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_vld_i | input | 1 | Encode request valid |
| enc_data_i | input | 4 | Nibble to encode |
| enc_vld_o | output | 1 | Codeword valid |
| enc_code_o | output | 8 | Encoded codeword |
| dec_vld_i | input | 1 | Decode request valid |
| dec_code_i | input | 8 | Received codeword |
| dec_vld_o | output | 1 | Decode result valid |
| dec_data_o | output | 4 | Corrected nibble |
| dec_fix_o | output | 1 | A single error was corrected |
| dec_dbl_o | output | 1 | An uncorrectable double error was seen |

## Verification
Two assertions relate the overall parity of the received codeword to the flags. They assume that no codeword fed to the decoder carries more than two flipped bits, because three flips would look like a single error. The stimulus keeps to that limit. Every decode input is built from a correct encoding with zero, one or two distinct positions flipped. The valid strobes are driven at random, so gaps and back-to-back requests both occur.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int CHK_W  = 3;
    localparam int CODE_W = (1 << CHK_W);
    localparam int DATA_W = CODE_W - CHK_W - 1;

    typedef logic [DATA_W-1:0] nib_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FIXED  = 2'd1,
        ST_DOUBLE = 2'd2
    } dec_st_e;

    typedef struct packed {
        nib_t    data;
        dec_st_e st;
    } dec_res_t;

    // 1-based position of data bit j: the j-th non-power-of-two index
    function automatic int data_pos(input int j);
        int cnt;
        cnt = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    // XOR of the indices of all set positions 1..CODE_W-1
    function automatic syn_t pos_syndrome(input code_t c);
        syn_t s;
        s = '0;
        for (int p = 1; p < CODE_W; p++)
            if (c[p-1]) s ^= syn_t'(p);
        return s;
    endfunction

    function automatic code_t place_data(input nib_t d);
        code_t c;
        c = '0;
        for (int j = 0; j < DATA_W; j++)
            c[data_pos(j)-1] = d[j];
        return c;
    endfunction

    function automatic nib_t pull_data(input code_t c);
        nib_t d;
        for (int j = 0; j < DATA_W; j++)
            d[j] = c[data_pos(j)-1];
        return d;
    endfunction
endpackage

// File: rtl/secded_enc_core.sv
module secded_enc_core
    import secded_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_i,
    input  nib_t  data_i,
    output logic  vld_o,
    output code_t code_o
);
    code_t with_data;
    syn_t  chk;
    code_t body;
    code_t full;

    assign with_data = place_data(data_i);
    assign chk       = pos_syndrome(with_data);

    // check bit k lives at position 2**k
    always_comb begin
        body = with_data;
        for (int k = 0; k < CHK_W; k++)
            body[(1 << k) - 1] = chk[k];
    end

    always_comb begin
        full = body;
        full[CODE_W-1] = ^body[CODE_W-2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            code_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) code_o <= full;
        end
    end

    AST_ENC_LAT_HI: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);  // R9
    AST_ENC_LAT_LO: assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_o); // R9
    AST_ENC_DATA: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> (code_o[2] == $past(data_i[0]) && code_o[4] == $past(data_i[1]) &&
                   code_o[5] == $past(data_i[2]) && code_o[6] == $past(data_i[3]))); // R1
    AST_ENC_EVEN: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> ($countones(code_o) % 2) == 0); // R3
endmodule

// File: rtl/secded_syn.sv
module secded_syn
    import secded_pkg::*;
(
    input  code_t    code_i,
    output dec_res_t res_o
);
    syn_t  syn;
    logic  par_bad;
    logic  [CODE_W-1:0] flip;

    assign syn     = pos_syndrome(code_i);
    assign par_bad = ^code_i;

    genvar k;
    generate
        for (k = 0; k < CODE_W - 1; k++) begin : g_flip
            assign flip[k] = (syn == syn_t'(k + 1));
        end
    endgenerate
    assign flip[CODE_W-1] = 1'b0;

    always_comb begin
        res_o.data = pull_data(code_i);
        res_o.st   = ST_CLEAN;
        unique case ({syn != '0, par_bad})
            2'b00: res_o.st = ST_CLEAN;
            2'b01: res_o.st = ST_FIXED;   // only the parity bit is wrong
            2'b11: begin
                res_o.st   = ST_FIXED;
                res_o.data = pull_data(code_i ^ flip);
            end
            default: res_o.st = ST_DOUBLE;
        endcase
    end
endmodule

// File: rtl/secded_dec_stage.sv
module secded_dec_stage
    import secded_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     vld_i,
    input  dec_res_t res_i,
    output logic     vld_o,
    output nib_t     data_o,
    output logic     fix_o,
    output logic     dbl_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
            fix_o  <= 1'b0;
            dbl_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            fix_o <= vld_i && (res_i.st == ST_FIXED);
            dbl_o <= vld_i && (res_i.st == ST_DOUBLE);
            if (vld_i) data_o <= res_i.data;
        end
    end

    AST_DEC_LAT_HI: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);  // R9
    AST_DEC_LAT_LO: assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_o); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst) !(fix_o && dbl_o)); // R10
    AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (rst) !vld_o |-> !(fix_o || dbl_o)); // R10
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_vld_i,
    input  logic [3:0] enc_data_i,
    output logic       enc_vld_o,
    output logic [7:0] enc_code_o,
    input  logic       dec_vld_i,
    input  logic [7:0] dec_code_i,
    output logic       dec_vld_o,
    output logic [3:0] dec_data_o,
    output logic       dec_fix_o,
    output logic       dec_dbl_o
);
    dec_res_t res;

    secded_enc_core u_enc (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (enc_vld_i),
        .data_i (enc_data_i),
        .vld_o  (enc_vld_o),
        .code_o (enc_code_o)
    );

    secded_syn u_syn (
        .code_i (dec_code_i),
        .res_o  (res)
    );

    secded_dec_stage u_dec (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (dec_vld_i),
        .res_i  (res),
        .vld_o  (dec_vld_o),
        .data_o (dec_data_o),
        .fix_o  (dec_fix_o),
        .dbl_o  (dec_dbl_o)
    );

    // Assumes at most two flipped bits per received codeword.
    AST_EVEN_NOFIX: assert property (@(posedge clk) disable iff (rst)
        (dec_vld_i && (^dec_code_i == 1'b0)) |=> !dec_fix_o); // R5
    AST_ODD_NODBL: assert property (@(posedge clk) disable iff (rst)
        (dec_vld_i && (^dec_code_i == 1'b1)) |=> !dec_dbl_o); // R6
endmodule

// File: tb/test_secded_codec.sv
`timescale 1ns/1ps
module test_secded_codec;
    logic       clk = 1'b0;
    logic       rst;
    logic       enc_vld_i, dec_vld_i;
    logic [3:0] enc_data_i;
    logic [7:0] dec_code_i;
    logic       enc_vld_o, dec_vld_o, dec_fix_o, dec_dbl_o;
    logic [7:0] enc_code_o;
    logic [3:0] dec_data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    secded_codec i_secded_codec (
        .clk(clk), .rst(rst),
        .enc_vld_i(enc_vld_i), .enc_data_i(enc_data_i),
        .enc_vld_o(enc_vld_o), .enc_code_o(enc_code_o),
        .dec_vld_i(dec_vld_i), .dec_code_i(dec_code_i),
        .dec_vld_o(dec_vld_o), .dec_data_o(dec_data_o),
        .dec_fix_o(dec_fix_o), .dec_dbl_o(dec_dbl_o)
    );

    function automatic logic [7:0] enc_ref(input logic [3:0] d);
        logic [7:0] c;
        c = '0;
        c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
        c[0] = d[0] ^ d[1] ^ d[3];
        c[1] = d[0] ^ d[2] ^ d[3];
        c[3] = d[1] ^ d[2] ^ d[3];
        c[7] = ^c[6:0];
        return c;
    endfunction

    function automatic logic [3:0] raw_data(input logic [7:0] c);
        return {c[6], c[5], c[4], c[2]};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ev, input logic [3:0] ed, input logic dv, input logic [7:0] dc);
        @(negedge clk);
        enc_vld_i = ev; enc_data_i = ed; dec_vld_i = dv; dec_code_i = dc;
        @(posedge clk);
        #1;
    endtask

    task automatic check_dec(input logic [3:0] exp_d, input logic exp_fix, input logic exp_dbl, input string tag);
        check(dec_vld_o == 1'b1, {tag, " valid"}, 8'(dec_vld_o), 8'd1);
        check(dec_data_o == exp_d, {tag, " data"}, 8'(dec_data_o), 8'(exp_d));
        check(dec_fix_o == exp_fix, {tag, " fix flag"}, 8'(dec_fix_o), 8'(exp_fix));
        check(dec_dbl_o == exp_dbl, {tag, " double flag"}, 8'(dec_dbl_o), 8'(exp_dbl));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; enc_vld_i = 0; dec_vld_i = 0; enc_data_i = 0; dec_code_i = 0;
        @(posedge clk); @(posedge clk); #1;
        // R11
        check(enc_vld_o == 0 && dec_vld_o == 0, "R11 valids in reset", {6'd0, enc_vld_o, dec_vld_o}, 8'd0);
        check(dec_fix_o == 0 && dec_dbl_o == 0, "R11 flags in reset", {6'd0, dec_fix_o, dec_dbl_o}, 8'd0);
        @(negedge clk); rst = 1'b0;

        // encode every nibble and decode its clean codeword
        for (int d = 0; d < 16; d++) begin
            logic [7:0] e;
            e = enc_ref(4'(d));
            step(1'b1, 4'(d), 1'b1, e);
            check(enc_vld_o == 1'b1, "R9 encode valid", 8'(enc_vld_o), 8'd1);
            check({enc_code_o[6:4], enc_code_o[2]} == {e[6:4], e[2]}, "R1 data placement", enc_code_o, e);
            check({enc_code_o[3], enc_code_o[1:0]} == {e[3], e[1:0]}, "R2 check bits", enc_code_o, e);
            check(enc_code_o[7] == e[7], "R3 overall parity", enc_code_o, e);
            if (d == 0) check(enc_code_o == 8'h00, "R4 zero nibble", enc_code_o, 8'h00);
            check_dec(4'(d), 1'b0, 1'b0, "R5 clean decode");
        end

        // single flips at each position
        for (int d = 0; d < 16; d++) begin
            for (int p = 0; p < 8; p++) begin
                step(1'b0, 4'd0, 1'b1, enc_ref(4'(d)) ^ (8'd1 << p));
                if (p < 7) check_dec(4'(d), 1'b1, 1'b0, "R6 single flip");
                else       check_dec(4'(d), 1'b1, 1'b0, "R7 parity bit flip");
            end
        end

        // random double flips
        for (int i = 0; i < 300; i++) begin
            logic [3:0] d;
            logic [7:0] c;
            int a, b;
            d = 4'($urandom);
            a = $urandom % 8;
            b = (a + 1 + ($urandom % 7)) % 8;
            c = enc_ref(d) ^ (8'd1 << a) ^ (8'd1 << b);
            step(1'b0, 4'd0, 1'b1, c);
            check_dec(raw_data(c), 1'b0, 1'b1, "R8 double flip");
        end

        // random valid patterns: latency and idle flags
        for (int i = 0; i < 400; i++) begin
            logic ev, dv;
            logic [3:0] d;
            logic [7:0] c;
            ev = 1'($urandom);
            dv = 1'($urandom);
            d  = 4'($urandom);
            c  = enc_ref(d) ^ (($urandom % 3 == 0) ? (8'd1 << ($urandom % 8)) : 8'd0);
            step(ev, d, dv, c);
            check(enc_vld_o == ev, "R9 encode latency", 8'(enc_vld_o), 8'(ev));
            check(dec_vld_o == dv, "R9 decode latency", 8'(dec_vld_o), 8'(dv));
            if (ev) check(enc_code_o == enc_ref(d), "R2 random encode", enc_code_o, enc_ref(d));
            if (dv) check_dec(d, c != enc_ref(d), 1'b0, "R6 random decode");
            else check(!dec_fix_o && !dec_dbl_o, "R10 flags idle", {6'd0, dec_fix_o, dec_dbl_o}, 8'd0);
        end

        // decode a double error, then go idle: flags must drop
        step(1'b0, 4'd0, 1'b1, enc_ref(4'h9) ^ 8'h03);
        check(dec_dbl_o && !dec_fix_o, "R10 exclusive flags", {6'd0, dec_fix_o, dec_dbl_o}, 8'd1);
        step(1'b0, 4'd0, 1'b0, 8'h00);
        check(!dec_vld_o && !dec_dbl_o && !dec_fix_o, "R10 flags after idle", {5'd0, dec_vld_o, dec_fix_o, dec_dbl_o}, 8'd0);

        // reset mid-traffic
        @(negedge clk); rst = 1'b1; enc_vld_i = 1; dec_vld_i = 1; dec_code_i = 8'h01;
        @(posedge clk); #1;
        check(!enc_vld_o && !dec_vld_o && !dec_fix_o && !dec_dbl_o, "R11 reset under traffic",
              {4'd0, enc_vld_o, dec_vld_o, dec_fix_o, dec_dbl_o}, 8'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule